// File: doc/BRIEF.md
# Three-Mailbox CAN Transmit Scheduler

This block holds the outgoing frames of a CAN controller in three transmit mailboxes and decides which of them goes to the protocol engine next. Each mailbox stores four words: an identifier word, a control word carrying the data length code, and two data words. Software fills an empty mailbox and then sets its request bit. From then on the mailbox is pending. Only one frame is in flight at a time.

The block offers the chosen frame to the protocol engine over a request/acknowledge pair. It then waits for exactly one result for that frame: delivered, error or arbitration lost. Frames can be scheduled in one of two ways, selected by a configuration input. The first is by identifier, where the lowest identifier goes first. The second is by request order, where the oldest request goes first. A second configuration input turns off automatic retransmission. Software can abort a waiting mailbox, and it can read a three-flag status per mailbox that tells pending, failed and succeeded apart. A finished flag raises the interrupt when the interrupt enable is set.

Top module: `can_tx_sched`

## Requirements
- R1: After a synchronous active-low reset, all three mailboxes are empty, every finished and success flag is clear, `eng_req` and `irq` are low, `free_idx` is 0 and `free_none` is low.
- R2: A write reaches mailbox `wr_mb` only while that mailbox is empty. Word select 0 is the identifier word, 1 the control word (only bits 3:0 are kept, as the DLC), 2 data word 0 and 3 data word 1. Writing the identifier word with bit 0 set makes the mailbox pending, which means empty, finished and success all read 0. Writes to a pending mailbox are ignored.
- R3: `free_idx` gives the lowest-numbered empty mailbox. `free_none` is high exactly when no mailbox is empty.
- R4: While no frame is in flight and at least one mailbox is pending, `eng_req` is high and `eng_mb`, `eng_id`, `eng_dlc`, `eng_d0` and `eng_d1` present the selected mailbox. `eng_req` together with `eng_ack` puts that frame in flight. No new frame is offered until the result for it arrives.
- R5: With `cfg_fifo_order` low, the pending mailbox whose identifier-word bits 31:3 form the smallest unsigned number is selected. On a tie, the lowest mailbox number wins.
- R6: With `cfg_fifo_order` high, the pending mailbox whose request was made earliest is selected.
- R7: `eng_done` for the frame in flight sets empty, finished and success of its mailbox.
- R8: With `cfg_no_retx` low, `eng_err` or `eng_lost` leaves the mailbox pending and ends the flight. The mailbox is offered again through normal selection.
- R9: With `cfg_no_retx` high, `eng_err` or `eng_lost` sets empty and finished of the mailbox and leaves success clear.
- R10: A `stop_req` bit aborts its mailbox only when that mailbox is pending and neither in flight nor acknowledged in the same cycle. An abort sets empty and finished and clears success. In every other case the request has no effect.
- R11: A `fin_clr` bit clears the finished and success flags of its mailbox. A result or abort on that mailbox in the same cycle takes precedence.
- R12: `irq` is high exactly when `cfg_tme_ie` is high and at least one finished flag is set.
- R13: Result inputs are ignored while no frame is in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_fifo_order | input | 1 | 1: oldest request first; 0: lowest identifier first |
| cfg_no_retx | input | 1 | 1: a single attempt per request |
| cfg_tme_ie | input | 1 | Interrupt enable for finished flags |
| wr_en | input | 1 | Mailbox word write strobe |
| wr_mb | input | 2 | Mailbox number for the write |
| wr_sel | input | 2 | Word select: 0 identifier, 1 control, 2 data 0, 3 data 1 |
| wr_data | input | 32 | Write data |
| stop_req | input | 3 | Per-mailbox abort request |
| fin_clr | input | 3 | Per-mailbox write-1-to-clear of the finished flag |
| free_idx | output | 2 | Lowest empty mailbox |
| free_none | output | 1 | No mailbox is empty |
| mb_empty | output | 3 | Empty flag per mailbox |
| mb_fin | output | 3 | Finished flag per mailbox |
| mb_ok | output | 3 | Finished-without-error flag per mailbox |
| irq | output | 1 | Transmit interrupt |
| eng_req | output | 1 | Frame offered to the protocol engine |
| eng_ack | input | 1 | Engine takes the offered frame |
| eng_mb | output | 2 | Mailbox number of the offered frame |
| eng_id | output | 32 | Identifier word of the offered frame |
| eng_dlc | output | 4 | Data length code of the offered frame |
| eng_d0 | output | 32 | Data bytes 0 to 3, byte 0 in bits 7:0 |
| eng_d1 | output | 32 | Data bytes 4 to 7, byte 4 in bits 7:0 |
| eng_done | input | 1 | Frame in flight delivered |
| eng_err | input | 1 | Frame in flight hit an error |
| eng_lost | input | 1 | Frame in flight lost arbitration |

## Verification
Every status flag, `free_idx`, `free_none` and `irq` change at the first rising edge that samples the write, abort, clear, acknowledge or result. The offer (`eng_req` and the frame fields) depends only on registered state, so it moves in that same cycle and never responds to an input in the cycle it is applied. The bench drives inputs after a falling edge and advances a behavioural model at each rising edge. It compares every output with the model at the next falling edge, which is one edge after the stimulus. Directed checks are sampled at the same falling edge.

// File: rtl/can_tx_pkg.sv
// Shared constants and types for the transmit scheduler.
package can_tx_pkg;
    localparam int unsigned WORD_W  = 32;
    localparam int unsigned DLC_W   = 4;
    localparam int unsigned KEY_LSB = 3;
    localparam int unsigned KEY_W   = WORD_W - KEY_LSB;

    typedef enum logic [1:0] {
        SEL_ID    = 2'd0,
        SEL_CTRL  = 2'd1,
        SEL_DATA0 = 2'd2,
        SEL_DATA1 = 2'd3
    } wsel_e;

    typedef struct packed {
        logic empty;
        logic fin;
        logic ok;
    } mb_stat_t;
endpackage

// File: rtl/can_tx_mailbox.sv
// One transmit mailbox: frame storage plus its empty/finished/success flags.
// Assumes the parent decodes the address, the in-flight condition and the
// final result for this mailbox. Writes land only while the mailbox is empty.
module can_tx_mailbox
    import can_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hit,
    input  logic [1:0]        wr_sel,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              stop,
    input  logic              fin_clr,
    input  logic              in_flight,
    input  logic              res_ok,
    input  logic              res_fail,
    output logic [WORD_W-1:0] id_word,
    output logic [DLC_W-1:0]  dlc,
    output logic [WORD_W-1:0] data0,
    output logic [WORD_W-1:0] data1,
    output mb_stat_t          stat,
    output logic              req_new
);
    logic wr_ok;
    logic stop_ok;

    assign wr_ok   = wr_hit & stat.empty;
    assign req_new = wr_ok & (wsel_e'(wr_sel) == SEL_ID) & wr_data[0];
    assign stop_ok = stop & ~stat.empty & ~in_flight;

    // Frame storage, written only while the mailbox is empty.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            id_word <= '0;
            dlc     <= '0;
            data0   <= '0;
            data1   <= '0;
        end else if (wr_ok) begin
            case (wsel_e'(wr_sel))
                SEL_ID:    id_word <= wr_data;
                SEL_CTRL:  dlc     <= wr_data[DLC_W-1:0];
                SEL_DATA0: data0   <= wr_data;
                default:   data1   <= wr_data;
            endcase
        end
    end

    // Status flags: result, then abort, then new request, then clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat <= '{empty: 1'b1, fin: 1'b0, ok: 1'b0};
        end else if (res_ok) begin
            stat <= '{empty: 1'b1, fin: 1'b1, ok: 1'b1};
        end else if (res_fail || stop_ok) begin
            stat <= '{empty: 1'b1, fin: 1'b1, ok: 1'b0};
        end else if (req_new) begin
            stat <= '{empty: 1'b0, fin: 1'b0, ok: 1'b0};
        end else if (fin_clr) begin
            stat.fin <= 1'b0;
            stat.ok  <= 1'b0;
        end
    end
endmodule

// File: rtl/can_tx_arbiter.sv
// Selects the next pending mailbox, either by lowest key (ties to the lowest
// index) or by request age kept in a pairwise older-than matrix.
// Assumes at most one new request per cycle.
module can_tx_arbiter #(
    parameter int unsigned N     = 3,
    parameter int unsigned KEY_W = 29,
    localparam int unsigned IW   = (N > 1) ? $clog2(N) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      fifo_mode,
    input  logic [N-1:0]              pend,
    input  logic [N-1:0][KEY_W-1:0]   keys,
    input  logic [N-1:0]              req_new,
    output logic                      any,
    output logic [IW-1:0]             win
);
    logic [N-1:0] older_q [N];
    logic [N-1:0] cand;

    // Age matrix: older_q[i][j] means mailbox i requested before mailbox j.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) older_q[i] <= '0;
        end else begin
            for (int i = 0; i < N; i++) begin
                for (int j = 0; j < N; j++) begin
                    if (i != j) begin
                        if (req_new[i])      older_q[i][j] <= 1'b0;
                        else if (req_new[j]) older_q[i][j] <= 1'b1;
                    end
                end
            end
        end
    end

    for (genvar gi = 0; gi < N; gi++) begin : g_cand
        logic c;
        // Candidate i survives when no other pending mailbox beats it.
        always_comb begin
            c = pend[gi];
            for (int j = 0; j < N; j++) begin
                if (j != gi) begin
                    if (fifo_mode) begin
                        if (pend[j] && older_q[j][gi]) c = 1'b0;
                    end else if (pend[j] &&
                                 !((keys[gi] < keys[j]) ||
                                   ((keys[gi] == keys[j]) && (gi < j)))) begin
                        c = 1'b0;
                    end
                end
            end
        end
        assign cand[gi] = c;
    end

    // Encode the surviving candidate, lowest index on any overlap.
    always_comb begin
        win = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (cand[i]) win = IW'(i);
        end
    end

    assign any = |pend;
endmodule

// File: rtl/can_tx_sched.sv
// Three-mailbox CAN transmit scheduler. Stores frames, chooses the next one
// for the protocol engine and keeps per-mailbox status. Assumes the engine
// returns exactly one result per acknowledged frame.
module can_tx_sched
    import can_tx_pkg::*;
#(
    parameter int unsigned NUM_MB = 3,
    localparam int unsigned MBW   = (NUM_MB > 1) ? $clog2(NUM_MB) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_fifo_order,
    input  logic              cfg_no_retx,
    input  logic              cfg_tme_ie,
    input  logic              wr_en,
    input  logic [MBW-1:0]    wr_mb,
    input  logic [1:0]        wr_sel,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [NUM_MB-1:0] stop_req,
    input  logic [NUM_MB-1:0] fin_clr,
    output logic [MBW-1:0]    free_idx,
    output logic              free_none,
    output logic [NUM_MB-1:0] mb_empty,
    output logic [NUM_MB-1:0] mb_fin,
    output logic [NUM_MB-1:0] mb_ok,
    output logic              irq,
    output logic              eng_req,
    input  logic              eng_ack,
    output logic [MBW-1:0]    eng_mb,
    output logic [WORD_W-1:0] eng_id,
    output logic [DLC_W-1:0]  eng_dlc,
    output logic [WORD_W-1:0] eng_d0,
    output logic [WORD_W-1:0] eng_d1,
    input  logic              eng_done,
    input  logic              eng_err,
    input  logic              eng_lost
);
    logic                          busy_q;
    logic [MBW-1:0]                busy_mb_q;
    logic                          any_pend;
    logic [MBW-1:0]                win;
    logic                          launch;
    logic                          fail_now;
    logic [NUM_MB-1:0]             req_new;
    logic [NUM_MB-1:0][KEY_W-1:0]  keys;
    logic [WORD_W-1:0]             id_words [NUM_MB];
    logic [DLC_W-1:0]              dlcs     [NUM_MB];
    logic [WORD_W-1:0]             d0s      [NUM_MB];
    logic [WORD_W-1:0]             d1s      [NUM_MB];
    mb_stat_t                      stat     [NUM_MB];

    assign launch   = eng_req & eng_ack;
    assign fail_now = ~eng_done & (eng_err | eng_lost) & cfg_no_retx;

    for (genvar gi = 0; gi < NUM_MB; gi++) begin : g_mb
        logic mine;
        assign mine = busy_q & (busy_mb_q == MBW'(gi));

        can_tx_mailbox u_mb (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_hit    (wr_en & (wr_mb == MBW'(gi))),
            .wr_sel    (wr_sel),
            .wr_data   (wr_data),
            .stop      (stop_req[gi]),
            .fin_clr   (fin_clr[gi]),
            .in_flight (mine | (launch & (win == MBW'(gi)))),
            .res_ok    (mine & eng_done),
            .res_fail  (mine & fail_now),
            .id_word   (id_words[gi]),
            .dlc       (dlcs[gi]),
            .data0     (d0s[gi]),
            .data1     (d1s[gi]),
            .stat      (stat[gi]),
            .req_new   (req_new[gi])
        );

        assign keys[gi]     = id_words[gi][WORD_W-1:KEY_LSB];
        assign mb_empty[gi] = stat[gi].empty;
        assign mb_fin[gi]   = stat[gi].fin;
        assign mb_ok[gi]    = stat[gi].ok;
    end

    can_tx_arbiter #(.N(NUM_MB), .KEY_W(KEY_W)) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .fifo_mode (cfg_fifo_order),
        .pend      (~mb_empty),
        .keys      (keys),
        .req_new   (req_new),
        .any       (any_pend),
        .win       (win)
    );

    // Single frame in flight: set on acknowledge, cleared by any result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q    <= 1'b0;
            busy_mb_q <= '0;
        end else if (launch) begin
            busy_q    <= 1'b1;
            busy_mb_q <= win;
        end else if (busy_q && (eng_done || eng_err || eng_lost)) begin
            busy_q    <= 1'b0;
        end
    end

    // Lowest-numbered empty mailbox for software.
    always_comb begin
        free_idx = '0;
        for (int i = NUM_MB - 1; i >= 0; i--) begin
            if (mb_empty[i]) free_idx = MBW'(i);
        end
    end

    assign free_none = ~|mb_empty;
    assign irq       = cfg_tme_ie & |mb_fin;
    assign eng_req   = ~busy_q & any_pend;
    assign eng_mb    = win;
    assign eng_id    = id_words[win];
    assign eng_dlc   = dlcs[win];
    assign eng_d0    = d0s[win];
    assign eng_d1    = d1s[win];
endmodule

// File: rtl/can_tx_sched_chk.sv
// Property checker for the transmit scheduler, attached by bind.
module can_tx_sched_chk #(
    parameter int unsigned NUM_MB = 3,
    localparam int unsigned MBW   = (NUM_MB > 1) ? $clog2(NUM_MB) : 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_tme_ie,
    input logic [NUM_MB-1:0] mb_empty,
    input logic [NUM_MB-1:0] mb_fin,
    input logic [NUM_MB-1:0] mb_ok,
    input logic              irq,
    input logic [MBW-1:0]    free_idx,
    input logic              free_none,
    input logic              eng_req,
    input logic              eng_ack,
    input logic [MBW-1:0]    eng_mb,
    input logic              eng_done,
    input logic              eng_err,
    input logic              eng_lost,
    input logic              busy_q,
    input logic [MBW-1:0]    busy_mb_q
);
    // R2: a pending mailbox shows all three flags clear
    a_r2_pending_clear: assert property (@(posedge clk) disable iff (!rst_n)
        ((mb_fin | mb_ok) & ~mb_empty) == '0);

    // R3: the reported free mailbox is really empty
    a_r3_free_is_empty: assert property (@(posedge clk) disable iff (!rst_n)
        !free_none |-> mb_empty[free_idx]);

    // R4: the offered mailbox is pending
    a_r4_offer_pending: assert property (@(posedge clk) disable iff (!rst_n)
        eng_req |-> !mb_empty[eng_mb]);

    // R4: after an acknowledge no new frame is offered in the next cycle
    a_r4_one_in_flight: assert property (@(posedge clk) disable iff (!rst_n)
        eng_req && eng_ack |=> !eng_req);

    // R7: a delivered frame leaves its mailbox finished with success
    a_r7_done_success: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q && eng_done |=> mb_ok[$past(busy_mb_q)] && mb_empty[$past(busy_mb_q)]);

    // R10: a mailbox in flight without a result stays pending
    a_r10_flight_kept: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q && !eng_done && !eng_err && !eng_lost |=> !mb_empty[$past(busy_mb_q)]);

    // R12: the interrupt needs its enable and a finished flag
    a_r12_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> cfg_tme_ie && (mb_fin != '0));
endmodule

bind can_tx_sched can_tx_sched_chk #(.NUM_MB(NUM_MB)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_tme_ie (cfg_tme_ie),
    .mb_empty   (mb_empty),
    .mb_fin     (mb_fin),
    .mb_ok      (mb_ok),
    .irq        (irq),
    .free_idx   (free_idx),
    .free_none  (free_none),
    .eng_req    (eng_req),
    .eng_ack    (eng_ack),
    .eng_mb     (eng_mb),
    .eng_done   (eng_done),
    .eng_err    (eng_err),
    .eng_lost   (eng_lost),
    .busy_q     (busy_q),
    .busy_mb_q  (busy_mb_q)
);

// File: tb/can_tx_sched_tb.sv
`timescale 1ns/1ps
module can_tx_sched_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_fifo_order = 1'b0, cfg_no_retx = 1'b0, cfg_tme_ie = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_mb = '0, wr_sel = '0;
    logic [31:0] wr_data = '0;
    logic [2:0]  stop_req = '0, fin_clr = '0;
    logic [1:0]  free_idx;
    logic        free_none;
    logic [2:0]  mb_empty, mb_fin, mb_ok;
    logic        irq, eng_req;
    logic        eng_ack = 1'b0, eng_done = 1'b0, eng_err = 1'b0, eng_lost = 1'b0;
    logic [1:0]  eng_mb;
    logic [31:0] eng_id, eng_d0, eng_d1;
    logic [3:0]  eng_dlc;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    can_tx_sched u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_fifo_order(cfg_fifo_order),
        .cfg_no_retx(cfg_no_retx), .cfg_tme_ie(cfg_tme_ie), .wr_en(wr_en),
        .wr_mb(wr_mb), .wr_sel(wr_sel), .wr_data(wr_data), .stop_req(stop_req),
        .fin_clr(fin_clr), .free_idx(free_idx), .free_none(free_none),
        .mb_empty(mb_empty), .mb_fin(mb_fin), .mb_ok(mb_ok), .irq(irq),
        .eng_req(eng_req), .eng_ack(eng_ack), .eng_mb(eng_mb), .eng_id(eng_id),
        .eng_dlc(eng_dlc), .eng_d0(eng_d0), .eng_d1(eng_d1),
        .eng_done(eng_done), .eng_err(eng_err), .eng_lost(eng_lost)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    bit [2:0]    m_empty, m_fin, m_ok;
    logic [31:0] m_id [3];
    logic [31:0] m_d0 [3];
    logic [31:0] m_d1 [3];
    logic [3:0]  m_dlc [3];
    int          m_stamp [3];
    int          stamp_ctr;
    bit          m_busy;
    int          m_bmb;
    bit          m_live = 1'b0;

    function automatic int m_winner();
        int best = -1;
        for (int i = 0; i < 3; i++) begin
            if (!m_empty[i]) begin
                if (best < 0) best = i;
                else if (cfg_fifo_order) begin
                    if (m_stamp[i] < m_stamp[best]) best = i;
                end else if ((m_id[i] >> 3) < (m_id[best] >> 3)) best = i;
            end
        end
        return best;
    endfunction

    always @(posedge clk) begin
        int w;
        bit ack;
        bit [2:0] pe;
        if (!rst_n) begin
            m_empty = 3'b111; m_fin = '0; m_ok = '0;
            for (int i = 0; i < 3; i++) begin
                m_id[i] = '0; m_d0[i] = '0; m_d1[i] = '0; m_dlc[i] = '0; m_stamp[i] = 0;
            end
            stamp_ctr = 0; m_busy = 0; m_bmb = 0; m_live = 1'b1;
        end else begin
            w   = m_winner();
            ack = !m_busy && (w >= 0) && eng_ack;
            pe  = m_empty;
            for (int i = 0; i < 3; i++)
                if (fin_clr[i]) begin m_fin[i] = 0; m_ok[i] = 0; end
            if (wr_en && wr_mb < 2'd3 && pe[wr_mb]) begin
                case (wr_sel)
                    2'd0: begin
                        m_id[wr_mb] = wr_data;
                        if (wr_data[0]) begin
                            m_empty[wr_mb] = 0; m_fin[wr_mb] = 0; m_ok[wr_mb] = 0;
                            m_stamp[wr_mb] = stamp_ctr; stamp_ctr++;
                        end
                    end
                    2'd1: m_dlc[wr_mb] = wr_data[3:0];
                    2'd2: m_d0[wr_mb] = wr_data;
                    default: m_d1[wr_mb] = wr_data;
                endcase
            end
            for (int i = 0; i < 3; i++)
                if (stop_req[i] && !pe[i] && !(m_busy && m_bmb == i) && !(ack && w == i)) begin
                    m_empty[i] = 1; m_fin[i] = 1; m_ok[i] = 0;
                end
            if (m_busy) begin
                if (eng_done) begin
                    m_empty[m_bmb] = 1; m_fin[m_bmb] = 1; m_ok[m_bmb] = 1; m_busy = 0;
                end else if (eng_err || eng_lost) begin
                    if (cfg_no_retx) begin
                        m_empty[m_bmb] = 1; m_fin[m_bmb] = 1; m_ok[m_bmb] = 0;
                    end
                    m_busy = 0;
                end
            end
            if (ack) begin m_busy = 1; m_bmb = w; end
        end
    end

    // Full comparison against the model at every falling edge.
    always @(negedge clk) begin
        int w;
        int f;
        if (rst_n && m_live) begin
            w = m_winner();
            f = 0;
            for (int i = 2; i >= 0; i--) if (m_empty[i]) f = i;
            chk("R2 model empty flags", 32'(mb_empty), 32'(m_empty));
            chk("R7 model finished flags", 32'(mb_fin), 32'(m_fin));
            chk("R9 model success flags", 32'(mb_ok), 32'(m_ok));
            chk("R3 model free_none", 32'(free_none), 32'(m_empty == 3'b000));
            chk("R3 model free_idx", 32'(free_idx), 32'(f));
            chk("R12 model irq", 32'(irq), 32'(cfg_tme_ie && m_fin != 0));
            chk("R4 model eng_req", 32'(eng_req), 32'(!m_busy && w >= 0));
            if (!m_busy && w >= 0) begin
                chk("R5 model eng_mb", 32'(eng_mb), 32'(w));
                chk("R4 model eng_id", eng_id, m_id[w]);
                chk("R4 model eng_dlc", 32'(eng_dlc), 32'(m_dlc[w]));
                chk("R4 model eng_d0", eng_d0, m_d0[w]);
                chk("R4 model eng_d1", eng_d1, m_d1[w]);
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr(int mb, int sel, logic [31:0] d);
        wr_en = 1; wr_mb = 2'(mb); wr_sel = 2'(sel); wr_data = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic load(int mb, logic [10:0] sid, logic [3:0] dlc, logic [31:0] d0, logic [31:0] d1);
        wr(mb, 1, 32'(dlc));
        wr(mb, 2, d0);
        wr(mb, 3, d1);
        wr(mb, 0, {sid, 21'd0} | 32'd1);
    endtask

    task automatic ack();
        eng_ack = 1; @(negedge clk); eng_ack = 0;
    endtask

    task automatic result(bit d, bit e, bit l);
        eng_done = d; eng_err = e; eng_lost = l;
        @(negedge clk);
        eng_done = 0; eng_err = 0; eng_lost = 0;
    endtask

    task automatic stop(logic [2:0] m);
        stop_req = m; @(negedge clk); stop_req = '0;
    endtask

    task automatic clr(logic [2:0] m);
        fin_clr = m; @(negedge clk); fin_clr = '0;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1: reset state
        chk("R1 empty", 32'(mb_empty), 32'h7);
        chk("R1 finished", 32'(mb_fin), 32'h0);
        chk("R1 success", 32'(mb_ok), 32'h0);
        chk("R1 eng_req", 32'(eng_req), 32'h0);
        chk("R1 irq", 32'(irq), 32'h0);
        chk("R1 free_idx", 32'(free_idx), 32'h0);
        chk("R1 free_none", 32'(free_none), 32'h0);

        // R2/R4/R7/R11/R12: single frame end to end
        cfg_tme_ie = 1;
        load(0, 11'h123, 4'd8, 32'h03020100, 32'h07060504);
        chk("R2 pending flags", 32'({mb_empty, mb_fin, mb_ok}), 32'({3'b110, 3'b000, 3'b000}));
        chk("R3 next free", 32'(free_idx), 32'h1);
        chk("R4 offer", 32'({eng_req, eng_mb}), 32'({1'b1, 2'd0}));
        chk("R4 id", eng_id, {11'h123, 21'd0} | 32'd1);
        chk("R4 dlc", 32'(eng_dlc), 32'h8);
        wr(0, 2, 32'hDEADBEEF);
        chk("R2 write to pending ignored", eng_d0, 32'h03020100);
        ack();
        chk("R4 no offer in flight", 32'(eng_req), 32'h0);
        result(1, 0, 0);
        chk("R7 success flags", 32'({mb_empty[0], mb_fin[0], mb_ok[0]}), 32'h7);
        chk("R12 irq on finish", 32'(irq), 32'h1);
        clr(3'b001);
        chk("R11 cleared", 32'({mb_fin[0], mb_ok[0]}), 32'h0);
        chk("R12 irq drops", 32'(irq), 32'h0);

        // R5/R3: identifier priority with a tie
        cfg_fifo_order = 0;
        load(0, 11'h300, 4'd1, 32'h11, 32'h0);
        load(1, 11'h100, 4'd2, 32'h22, 32'h0);
        load(2, 11'h100, 4'd3, 32'h33, 32'h0);
        chk("R3 all busy", 32'(free_none), 32'h1);
        chk("R5 lowest id", 32'(eng_mb), 32'h1);
        ack(); result(1, 0, 0);
        chk("R5 tie to lower index", 32'(eng_mb), 32'h2);
        ack(); result(1, 0, 0);
        chk("R5 last", 32'(eng_mb), 32'h0);
        ack(); result(1, 0, 0);
        clr(3'b111);

        // R6: request order
        cfg_fifo_order = 1;
        load(2, 11'h700, 4'd1, 32'h1, 32'h0);
        load(0, 11'h600, 4'd1, 32'h2, 32'h0);
        load(1, 11'h001, 4'd1, 32'h3, 32'h0);
        chk("R6 oldest first", 32'(eng_mb), 32'h2);
        ack(); result(1, 0, 0);
        chk("R6 second", 32'(eng_mb), 32'h0);
        ack(); result(1, 0, 0);
        chk("R6 third", 32'(eng_mb), 32'h1);
        ack(); result(1, 0, 0);
        clr(3'b111);

        // R8: automatic retransmission
        cfg_fifo_order = 0;
        load(1, 11'h050, 4'd4, 32'h44, 32'h55);
        ack(); result(0, 1, 0);
        chk("R8 still pending after error", 32'({mb_empty[1], mb_fin[1]}), 32'h0);
        chk("R8 offered again", 32'({eng_req, eng_mb}), 32'({1'b1, 2'd1}));
        ack(); result(0, 0, 1);
        chk("R8 offered after loss", 32'({eng_req, eng_mb}), 32'({1'b1, 2'd1}));
        ack(); result(1, 0, 0);
        clr(3'b010);

        // R9: single attempt
        cfg_no_retx = 1;
        load(0, 11'h010, 4'd0, 32'h0, 32'h0);
        ack(); result(0, 1, 0);
        chk("R9 failed on error", 32'({mb_empty[0], mb_fin[0], mb_ok[0]}), 32'h6);
        clr(3'b001);
        load(0, 11'h010, 4'd0, 32'h0, 32'h0);
        ack(); result(0, 0, 1);
        chk("R9 failed on loss", 32'({mb_empty[0], mb_fin[0], mb_ok[0]}), 32'h6);
        clr(3'b001);
        cfg_no_retx = 0;

        // R10: aborts
        load(0, 11'h010, 4'd1, 32'h9, 32'h0);
        load(2, 11'h020, 4'd1, 32'hA, 32'h0);
        ack();
        stop(3'b111);
        chk("R10 in-flight not aborted", 32'(mb_empty[0]), 32'h0);
        chk("R10 pending aborted", 32'({mb_empty[2], mb_fin[2], mb_ok[2]}), 32'h6);
        chk("R10 empty mailbox unaffected", 32'({mb_empty[1], mb_fin[1]}), 32'h2);
        result(1, 0, 0);
        chk("R10 in-flight completes", 32'(mb_ok[0]), 32'h1);
        clr(3'b111);

        // R13: results ignored while idle
        result(1, 0, 0);
        chk("R13 idle done ignored", 32'({mb_empty, mb_fin}), 32'({3'b111, 3'b000}));
        cfg_no_retx = 1;
        load(1, 11'h005, 4'd2, 32'h7, 32'h0);
        result(0, 1, 0);
        chk("R13 idle error ignored", 32'({mb_empty[1], eng_req}), 32'h1);
        ack(); result(1, 0, 0);
        cfg_tme_ie = 0;
        @(negedge clk);
        chk("R12 irq masked", 32'(irq), 32'h0);
        clr(3'b010);
        cfg_no_retx = 0;

        repeat (2) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule